// File: doc/BRIEF.md
# Calendar Real-Time Clock with Update Handshake

A memory-mapped real-time clock peripheral. It counts wall-clock time from a one-second strobe supplied on `tick_i`. Hours, minutes and seconds live in a time register. Century, year, month, day of month and day of week live in a calendar register. Every field is held in BCD and counting is always 24-hour. At midnight the time counter carries into the calendar. The calendar follows month lengths, including February 29 in Gregorian leap years. Year 99 carries into the century.

Software reaches the block over a simple 32-bit word register bus. To set the clock, software raises the update request for the time group, the calendar group or both. It then waits for the update-acknowledge status flag, writes the new values and drops the request. The block checks every value written during an update. An out-of-range value is refused: the old value stays and an error flag is latched. Five sticky status flags feed an interrupt output through an enable mask.

Top module: `rtc_calendar_core`

## Requirements
- R1: The register word addresses are: 0 control (bit0 update-time request, bit1 update-calendar request, read/write), 1 mode (bit0, read/write), 2 time, 3 calendar, 4 status (read only), 5 status clear (write only), 6 interrupt enable-set (reads the mask), 7 interrupt disable (write only), 8 valid-entry (bit0 bad time, bit1 bad calendar, read only). Unused and write-only addresses read 0, and reads have no side effects.
- R2: After reset, time reads 00:00:00, and the calendar reads century 0x19, year 0x00, month 0x01, day 0x01, weekday 1. Control, mode, status, mask and valid-entry read 0, and `irq_o` is low.
- R3: The time register holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, all BCD. Each counted tick advances the seconds. 59 seconds wraps to 00 and adds a minute, 59 minutes wraps and adds an hour, and hour 23 wraps to 00.
- R4: The calendar register holds the century in bits 7:0, the year in 15:8, the month in 20:16, the weekday (1..7) in 23:21 and the day in 29:24, all BCD except the weekday. A midnight wrap of the time advances the day and weekday (7 wraps to 1). The last day of a month moves to day 1 of the next month. February has 29 days when the year is a multiple of 4, except year 00, which is a leap year only if the century is a multiple of 4. December moves to January of the next year, year 99 moves to 00 with the century incremented, and century 99 wraps to 00.
- R5: Setting an update request bit leaves that group counting until the next tick. That tick is still counted, sets the acknowledge flag (status bit0) and stops the group. While stopped the group ignores ticks, and a stopped calendar ignores midnight carries. Clearing the request lets the group count again from the first tick after the request bit reads 0.
- R6: A write to the time or calendar register is taken only while that group is stopped. At any other time it is ignored, with no effect on any register.
- R7: A write taken during an update is loaded only if every field is a valid value in range. Otherwise the old value stays, valid-entry bit0 (time) or bit1 (calendar) is set, and status bit4 is set. A valid write clears the matching valid-entry bit. An all-zero calendar value is invalid.
- R8: Status bit1 sets on every counted second, bit2 when the seconds wrap, and bit3 when the time wraps at midnight. Status bits stay set until a 1 is written to the same bit of the status-clear register. An event in the same cycle as its clear leaves the bit set.
- R9: `irq_o` is high exactly when some status bit is set whose mask bit is set. A write to enable-set ORs its low five bits into the mask. A write to disable clears the mask bits written as 1, so writing all ones masks every source.
- R10: The mode register keeps bit0 as written. Counting is 24-hour in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe, one per second |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as a read select |
| irq_o | output | 1 | Interrupt, level |

## Verification
The collision that matters most is a counted second meeting a status-clear write for the same flag in one cycle. The bench drives a tick and a clear of the second-event bit on the same edge and expects the flag still set. The same meeting happens many more times in a long random stretch of ticks mixed with clears and mask writes. A second overlap is a midnight carry arriving while only the calendar is stopped. The bench lets the time run through midnight under a calendar-only update and expects the day to stay put. The behavioural model predicts both cases, and every readable register and the interrupt are compared with it after each clock.

// File: rtl/rtc_cal_pkg.sv
// Shared types, constants and BCD helper functions for the calendar RTC.
// Assumes every stored field is BCD and the weekday is binary 1..7.
package rtc_cal_pkg;

    localparam int NUM_EV = 5;
    localparam int EV_ACK = 0;
    localparam int EV_SEC = 1;
    localparam int EV_MIN = 2;
    localparam int EV_DAY = 3;
    localparam int EV_REJ = 4;

    localparam int A_CTRL = 0;
    localparam int A_MODE = 1;
    localparam int A_TIME = 2;
    localparam int A_CAL  = 3;
    localparam int A_STAT = 4;
    localparam int A_CLR  = 5;
    localparam int A_IEN  = 6;
    localparam int A_IDIS = 7;
    localparam int A_VER  = 8;

    typedef struct packed {
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    // Packed MSB first so that {2'b0, rtc_date_t} is the calendar register.
    typedef struct packed {
        logic [5:0] day;
        logic [2:0] dow;
        logic [4:0] mon;
        logic [7:0] yr;
        logic [7:0] cen;
    } rtc_date_t;

    localparam rtc_time_t TIME_RST = '{hour: 6'h00, min: 7'h00, sec: 7'h00};
    localparam rtc_date_t DATE_RST = '{day: 6'h01, dow: 3'd1, mon: 5'h01,
                                       yr: 8'h00, cen: 8'h19};

    function automatic logic digits_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [6:0] bcd_bin(input logic [7:0] v);
        return 7'({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
    endfunction

    function automatic logic is_leap(input logic [7:0] cen, input logic [7:0] yr);
        logic [6:0] c;
        logic [6:0] y;
        c = bcd_bin(cen);
        y = bcd_bin(yr);
        if (y == 7'd0) return c[1:0] == 2'd0;
        return y[1:0] == 2'd0;
    endfunction

    function automatic logic [5:0] last_day(input logic [4:0] mon,
                                            input logic [7:0] cen,
                                            input logic [7:0] yr);
        case (mon)
            5'h02:                      return is_leap(cen, yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic time_ok(input rtc_time_t t);
        return digits_ok({1'b0, t.sec}) && (t.sec <= 7'h59) &&
               digits_ok({1'b0, t.min}) && (t.min <= 7'h59) &&
               digits_ok({2'b0, t.hour}) && (t.hour <= 6'h23);
    endfunction

    function automatic logic date_ok(input rtc_date_t d);
        return digits_ok(d.cen) && digits_ok(d.yr) &&
               digits_ok({3'b0, d.mon}) && (d.mon >= 5'h01) && (d.mon <= 5'h12) &&
               digits_ok({2'b0, d.day}) && (d.day >= 6'h01) &&
               (d.day <= last_day(d.mon, d.cen, d.yr)) &&
               (d.dow >= 3'd1) && (d.dow <= 3'd7);
    endfunction

endpackage

// File: rtl/rtc_time_unit.sv
// Hours/minutes/seconds BCD counter.
// Assumes adv and ld are never both high (the top only loads while stopped).
// Flags a seconds wrap and a midnight wrap in the cycle the advance is applied.
module rtc_time_unit
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      ld,
    input  rtc_time_t ld_val,
    output rtc_time_t cur,
    output logic      min_wrap,
    output logic      day_wrap
);
    logic      sec_top;
    logic      min_top;
    logic      hr_top;
    rtc_time_t nxt;

    // Detect the last value of each field.
    always_comb begin
        sec_top = (cur.sec  == 7'h59);
        min_top = (cur.min  == 7'h59);
        hr_top  = (cur.hour == 6'h23);
    end

    // Next count with BCD carries rippling upward.
    always_comb begin
        nxt = cur;
        if (sec_top) begin
            nxt.sec = 7'h00;
            if (min_top) begin
                nxt.min  = 7'h00;
                nxt.hour = hr_top ? 6'h00 : 6'(bcd_inc({2'b0, cur.hour}));
            end else begin
                nxt.min = 7'(bcd_inc({1'b0, cur.min}));
            end
        end else begin
            nxt.sec = 7'(bcd_inc({1'b0, cur.sec}));
        end
    end

    // Wrap strobes for the status flags and the calendar.
    always_comb begin
        min_wrap = adv && sec_top;
        day_wrap = adv && sec_top && min_top && hr_top;
    end

    // Time register: load wins, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur <= TIME_RST;
        else if (ld)  cur <= ld_val;
        else if (adv) cur <= nxt;
    end
endmodule

// File: rtl/rtc_date_unit.sv
// Century/year/month/day/weekday BCD counter with month lengths and leap years.
// Assumes the stored value is always valid (loads are checked upstream).
module rtc_date_unit
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      ld,
    input  rtc_date_t ld_val,
    output rtc_date_t cur
);
    rtc_date_t  nxt;
    logic [5:0] dim;

    // Last day of the current month.
    always_comb dim = last_day(cur.mon, cur.cen, cur.yr);

    // Next calendar day with month, year and century carries.
    always_comb begin
        nxt     = cur;
        nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
        if (cur.day == dim) begin
            nxt.day = 6'h01;
            if (cur.mon == 5'h12) begin
                nxt.mon = 5'h01;
                if (cur.yr == 8'h99) begin
                    nxt.yr  = 8'h00;
                    nxt.cen = (cur.cen == 8'h99) ? 8'h00 : bcd_inc(cur.cen);
                end else begin
                    nxt.yr = bcd_inc(cur.yr);
                end
            end else begin
                nxt.mon = 5'(bcd_inc({3'b0, cur.mon}));
            end
        end else begin
            nxt.day = 6'(bcd_inc({2'b0, cur.day}));
        end
    end

    // Calendar register: load wins, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur <= DATE_RST;
        else if (ld)  cur <= ld_val;
        else if (adv) cur <= nxt;
    end
endmodule

// File: rtl/rtc_entry_check.sv
// Splits a bus word into time and calendar fields and judges their range.
// Purely combinational; assumes DATA_W covers bit 29.
module rtc_entry_check
    import rtc_cal_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] wdata,
    output rtc_time_t         time_val,
    output rtc_date_t         date_val,
    output logic              time_good,
    output logic              date_good
);
    // Field extraction following the register layouts.
    always_comb begin
        time_val.sec  = wdata[6:0];
        time_val.min  = wdata[14:8];
        time_val.hour = wdata[21:16];
        date_val      = wdata[29:0];
    end

    // Range judgement.
    always_comb begin
        time_good = time_ok(time_val);
        date_good = date_ok(date_val);
    end
endmodule

// File: rtl/rtc_event_ctrl.sv
// Sticky status flags, interrupt mask and interrupt output.
// Assumes set and clear for one bit may coincide; set then wins.
module rtc_event_ctrl #(
    parameter int NUM = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    input  logic [NUM-1:0] en_set_i,
    input  logic [NUM-1:0] en_clr_i,
    output logic [NUM-1:0] stat_o,
    output logic [NUM-1:0] mask_o,
    output logic           irq_o
);
    for (genvar i = 0; i < NUM; i++) begin : g_bit
        // One sticky flag: an event beats a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)        stat_o[i] <= 1'b0;
            else if (set_i[i]) stat_o[i] <= 1'b1;
            else if (clr_i[i]) stat_o[i] <= 1'b0;
        end

        // One mask bit: enable-set and disable come from separate addresses.
        always_ff @(posedge clk) begin
            if (!rst_n)           mask_o[i] <= 1'b0;
            else if (en_set_i[i]) mask_o[i] <= 1'b1;
            else if (en_clr_i[i]) mask_o[i] <= 1'b0;
        end
    end

    // Level interrupt from the masked flags.
    always_comb irq_o = |(stat_o & mask_o);
endmodule

// File: rtl/rtc_calendar_core.sv
// Top of the calendar RTC: register bus, update handshake and write gating.
// Assumes tick_i is a one-cycle strobe and reads are combinational and free of
// side effects. Each group stops on the first tick after its request is set.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic              wr_ctrl, wr_mode, wr_time, wr_cal, wr_clr, wr_ien, wr_idis;
    logic [1:0]        ctrl_q;
    logic              mode_q;
    logic [1:0]        ver_q;
    logic              t_halt_q, c_halt_q;
    logic              t_adv, c_adv, t_ld, c_ld;
    logic              min_wrap, day_wrap;
    rtc_time_t         time_cur, time_wr;
    rtc_date_t         date_cur, date_wr;
    logic              time_good, date_good;
    logic [NUM_EV-1:0] ev_set, ev_clr, en_set, en_clr, stat_q, mask_q;

    // Write strobes per register.
    always_comb begin
        wr_ctrl = bus_sel && bus_we && (bus_addr == ADDR_W'(A_CTRL));
        wr_mode = bus_sel && bus_we && (bus_addr == ADDR_W'(A_MODE));
        wr_time = bus_sel && bus_we && (bus_addr == ADDR_W'(A_TIME));
        wr_cal  = bus_sel && bus_we && (bus_addr == ADDR_W'(A_CAL));
        wr_clr  = bus_sel && bus_we && (bus_addr == ADDR_W'(A_CLR));
        wr_ien  = bus_sel && bus_we && (bus_addr == ADDR_W'(A_IEN));
        wr_idis = bus_sel && bus_we && (bus_addr == ADDR_W'(A_IDIS));
    end

    // Control and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 2'b00;
            mode_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
            if (wr_mode) mode_q <= bus_wdata[0];
        end
    end

    // Stop state per group: entered on a tick while requested, left when the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_halt_q <= 1'b0;
            c_halt_q <= 1'b0;
        end else begin
            t_halt_q <= ctrl_q[0] && (t_halt_q || tick_i);
            c_halt_q <= ctrl_q[1] && (c_halt_q || tick_i);
        end
    end

    rtc_entry_check #(.DATA_W(DATA_W)) u_check (
        .wdata     (bus_wdata),
        .time_val  (time_wr),
        .date_val  (date_wr),
        .time_good (time_good),
        .date_good (date_good)
    );

    // Advance and load qualifiers.
    always_comb begin
        t_adv = tick_i && !t_halt_q;
        c_adv = day_wrap && !c_halt_q;
        t_ld  = wr_time && t_halt_q && time_good;
        c_ld  = wr_cal  && c_halt_q && date_good;
    end

    rtc_time_unit u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (t_adv),
        .ld       (t_ld),
        .ld_val   (time_wr),
        .cur      (time_cur),
        .min_wrap (min_wrap),
        .day_wrap (day_wrap)
    );

    rtc_date_unit u_date (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (c_adv),
        .ld     (c_ld),
        .ld_val (date_wr),
        .cur    (date_cur)
    );

    // Valid-entry flags, judged again on every taken write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ver_q <= 2'b00;
        end else begin
            if (wr_time && t_halt_q) ver_q[0] <= !time_good;
            if (wr_cal  && c_halt_q) ver_q[1] <= !date_good;
        end
    end

    // Status event sources, clears and mask updates.
    always_comb begin
        ev_set         = '0;
        ev_set[EV_ACK] = tick_i && ((ctrl_q[0] && !t_halt_q) || (ctrl_q[1] && !c_halt_q));
        ev_set[EV_SEC] = t_adv;
        ev_set[EV_MIN] = min_wrap;
        ev_set[EV_DAY] = day_wrap;
        ev_set[EV_REJ] = (wr_time && t_halt_q && !time_good) ||
                         (wr_cal  && c_halt_q && !date_good);
        ev_clr = wr_clr  ? bus_wdata[NUM_EV-1:0] : '0;
        en_set = wr_ien  ? bus_wdata[NUM_EV-1:0] : '0;
        en_clr = wr_idis ? bus_wdata[NUM_EV-1:0] : '0;
    end

    rtc_event_ctrl #(.NUM(NUM_EV)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_set),
        .clr_i    (ev_clr),
        .en_set_i (en_set),
        .en_clr_i (en_clr),
        .stat_o   (stat_q),
        .mask_o   (mask_q),
        .irq_o    (irq_o)
    );

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                ADDR_W'(A_CTRL): bus_rdata = DATA_W'(ctrl_q);
                ADDR_W'(A_MODE): bus_rdata = DATA_W'(mode_q);
                ADDR_W'(A_TIME): bus_rdata = DATA_W'({time_cur.hour, 1'b0, time_cur.min,
                                                      1'b0, time_cur.sec});
                ADDR_W'(A_CAL):  bus_rdata = DATA_W'(date_cur);
                ADDR_W'(A_STAT): bus_rdata = DATA_W'(stat_q);
                ADDR_W'(A_IEN):  bus_rdata = DATA_W'(mask_q);
                ADDR_W'(A_VER):  bus_rdata = DATA_W'(ver_q);
                default:         bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for the calendar RTC, attached to the top by bind.
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        t_halt,
    input logic        t_ld,
    input rtc_time_t   time_q,
    input rtc_date_t   date_q,
    input logic [4:0]  stat_q,
    input logic [4:0]  mask_q,
    input logic [1:0]  ver_q,
    input logic        irq_o,
    input logic        wr_time,
    input logic        wr_clr,
    input logic [4:0]  clr_bits
);
    // R3
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q.sec[3:0] <= 4'd9) && (time_q.sec[6:4] <= 3'd5));

    // R4
    date_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (date_q.day != 6'h00) && (date_q.mon != 5'h00) && (date_q.dow != 3'd0));

    // R5
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_halt && !t_ld) |=> $stable(time_q));

    // R5
    ack_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !stat_q[0]) |=> !stat_q[0]);

    // R6
    run_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_halt && !tick_i) |=> $stable(time_q));

    // R7
    ver_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_time |=> $stable(ver_q[0]));

    // R8
    sec_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !(wr_clr && clr_bits[1])) |=> stat_q[1]);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 5'd0) |-> !irq_o);
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .t_halt   (t_halt_q),
    .t_ld     (t_ld),
    .time_q   (time_cur),
    .date_q   (date_cur),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .ver_q    (ver_q),
    .irq_o    (irq_o),
    .wr_time  (wr_time),
    .wr_clr   (wr_clr),
    .clr_bits (bus_wdata[4:0])
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/100ps
module sim_rtc_calendar_core;
    localparam int AW = 4;
    localparam int A_CTRL = 0, A_MODE = 1, A_TIME = 2, A_CAL = 3, A_STAT = 4;
    localparam int A_CLR = 5, A_IEN = 6, A_IDIS = 7, A_VER = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural model state
    int hh, mm, ss, cen, yr, mon, day, dow;
    int ctrl, mode, ver, stat, mask, th, ch;

    always #5 clk = ~clk;

    rtc_calendar_core #(.DATA_W(32), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic int bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int dec(input int hi, input int lo);
        if (hi > 9 || lo > 9) return -1;
        return hi * 10 + lo;
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return ((y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0))) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] tword(input int h, input int m, input int s);
        return 32'((bcd(h) << 16) | (bcd(m) << 8) | bcd(s));
    endfunction

    function automatic logic [31:0] cword(input int c, input int y, input int mo,
                                          input int d, input int w);
        return 32'((bcd(d) << 24) | (w << 21) | (bcd(mo) << 16) | (bcd(y) << 8) | bcd(c));
    endfunction

    task automatic model_reset();
        hh = 0; mm = 0; ss = 0; cen = 19; yr = 0; mon = 1; day = 1; dow = 1;
        ctrl = 0; mode = 0; ver = 0; stat = 0; mask = 0; th = 0; ch = 0;
    endtask

    // One clock of the model, all decisions on pre-edge state.
    task automatic model_step(input bit tk, input bit w, input int a, input logic [31:0] d);
        int ev, clr, nth, nch, s, mi, h, c, y, mo, dy, wd;
        bit ok;
        ev = 0; clr = 0;
        if (tk && ((((ctrl & 1) != 0) && th == 0) || (((ctrl & 2) != 0) && ch == 0))) ev |= 1;
        if (tk && th == 0) begin
            ss++; ev |= 2;
            if (ss == 60) begin
                ss = 0; mm++; ev |= 4;
                if (mm == 60) begin
                    mm = 0; hh++;
                    if (hh == 24) begin
                        hh = 0; ev |= 8;
                        if (ch == 0) begin
                            day++; dow = (dow == 7) ? 1 : dow + 1;
                            if (day > mdays(mon, cen * 100 + yr)) begin
                                day = 1; mon++;
                                if (mon > 12) begin
                                    mon = 1; yr++;
                                    if (yr == 100) begin yr = 0; cen = (cen + 1) % 100; end
                                end
                            end
                        end
                    end
                end
            end
        end
        nth = (((ctrl & 1) != 0) && (th != 0 || tk)) ? 1 : 0;
        nch = (((ctrl & 2) != 0) && (ch != 0 || tk)) ? 1 : 0;
        if (w) begin
            case (a)
                A_CTRL: ctrl = int'(d[1:0]);
                A_MODE: mode = int'(d[0]);
                A_TIME: if (th != 0) begin
                    s  = dec(int'(d[6:4]), int'(d[3:0]));
                    mi = dec(int'(d[14:12]), int'(d[11:8]));
                    h  = dec(int'(d[21:20]), int'(d[19:16]));
                    ok = (s >= 0 && s < 60 && mi >= 0 && mi < 60 && h >= 0 && h < 24);
                    if (ok) begin ss = s; mm = mi; hh = h; ver &= ~1; end
                    else begin ver |= 1; ev |= 16; end
                end
                A_CAL: if (ch != 0) begin
                    c  = dec(int'(d[7:4]), int'(d[3:0]));
                    y  = dec(int'(d[15:12]), int'(d[11:8]));
                    mo = dec(int'(d[20]), int'(d[19:16]));
                    dy = dec(int'(d[29:28]), int'(d[27:24]));
                    wd = int'(d[23:21]);
                    ok = (c >= 0 && y >= 0 && mo >= 1 && mo <= 12 && dy >= 1 &&
                          wd >= 1 && wd <= 7);
                    if (ok) ok = (dy <= mdays(mo, c * 100 + y));
                    if (ok) begin cen = c; yr = y; mon = mo; day = dy; dow = wd; ver &= ~2; end
                    else begin ver |= 2; ev |= 16; end
                end
                A_CLR:  clr = int'(d[4:0]);
                A_IEN:  mask |= int'(d[4:0]);
                A_IDIS: mask &= ~int'(d[4:0]);
                default: ;
            endcase
        end
        stat = ((stat & ~clr) | ev) & 31;
        th = nth; ch = nch;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Read every readable register and the interrupt, compare with the model.
    task automatic sweep();
        bus_sel = 1'b1; bus_we = 1'b0;
        bus_addr = AW'(A_CTRL); #0.4 check("R1 R5 control", bus_rdata, 32'(ctrl));
        bus_addr = AW'(A_MODE); #0.4 check("R10 mode", bus_rdata, 32'(mode));
        bus_addr = AW'(A_TIME); #0.4 check("R3 time", bus_rdata, tword(hh, mm, ss));
        bus_addr = AW'(A_CAL);  #0.4 check("R4 calendar", bus_rdata, cword(cen, yr, mon, day, dow));
        bus_addr = AW'(A_STAT); #0.4 check("R8 status", bus_rdata, 32'(stat));
        bus_addr = AW'(A_IEN);  #0.4 check("R9 mask", bus_rdata, 32'(mask));
        bus_addr = AW'(A_VER);  #0.4 check("R7 valid-entry", bus_rdata, 32'(ver));
        bus_addr = AW'(A_CLR);  #0.4 check("R1 write-only reads 0", bus_rdata, 32'd0);
        check("R9 irq", 32'(irq_o), 32'((stat & mask) != 0));
        bus_sel = 1'b0;
    endtask

    task automatic step(input bit tk, input bit w, input int a, input logic [31:0] d);
        @(negedge clk);
        tick_i = tk; bus_sel = w; bus_we = w; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk);
        model_step(tk, w, a, d);
        #1;
        tick_i = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        sweep();
    endtask

    task automatic idle();        step(0, 0, 0, 32'd0); endtask
    task automatic tick();        step(1, 0, 0, 32'd0); endtask
    task automatic wr(input int a, input logic [31:0] d); step(0, 1, a, d); endtask

    // Full update of both groups through the handshake.
    task automatic set_clock(input logic [31:0] t, input logic [31:0] c);
        wr(A_CTRL, 32'd3); idle(); tick(); idle();
        wr(A_TIME, t); wr(A_CAL, c);
        wr(A_CTRL, 32'd0); idle(); wr(A_CLR, 32'h1F);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5 sweep();                                   // R2 reset state

        repeat (3) begin tick(); idle(); end            // R3 counting
        wr(A_IEN, 32'h02); tick(); idle();              // R9 irq on second event
        wr(A_CLR, 32'h1F); idle();                      // R8 clear

        wr(A_CTRL, 32'd1); idle(); idle();              // R5 request, no ack yet
        tick(); idle(); tick(); tick();                 // R5 ack then frozen
        wr(A_TIME, tword(23, 59, 58));                  // R6 taken while stopped
        wr(A_TIME, 32'h0000_0060);                      // R7 bad seconds
        wr(A_TIME, 32'h0024_0000);                      // R7 bad hour
        wr(A_CAL, cword(20, 24, 2, 28, 3));             // R6 calendar running: ignored
        wr(A_TIME, tword(23, 59, 58));                  // R7 good write clears flag
        wr(A_CLR, 32'h1F);
        wr(A_CTRL, 32'd3); tick(); idle();              // R5 calendar ack
        wr(A_CAL, 32'd0);                               // R7 all-zero invalid
        wr(A_CAL, cword(20, 24, 2, 30, 3));             // R7 Feb 30 invalid
        wr(A_CAL, cword(20, 24, 2, 28, 7));             // R4 good
        wr(A_CTRL, 32'd0); idle();
        repeat (3) begin tick(); idle(); end            // R4 Feb 28 -> Feb 29 leap

        set_clock(tword(23, 59, 59), cword(20, 24, 2, 29, 4));
        tick(); idle();                                 // R4 Feb 29 -> Mar 1
        set_clock(tword(23, 59, 59), cword(20, 99, 12, 31, 7));
        tick(); idle();                                 // R4 year 99 -> century
        set_clock(tword(23, 59, 59), cword(21, 0, 2, 29, 1));  // R7 2100-02-29 invalid
        set_clock(tword(23, 59, 59), cword(21, 0, 2, 28, 1));
        tick(); idle();                                 // R4 2100 not leap
        set_clock(tword(23, 59, 59), cword(20, 0, 2, 28, 1));
        tick(); idle();                                 // R4 2000 leap
        set_clock(tword(23, 59, 59), cword(99, 99, 12, 31, 5));
        tick(); idle();                                 // R4 century 99 wraps

        set_clock(tword(23, 59, 58), cword(20, 30, 6, 30, 6));
        wr(A_CTRL, 32'd2); tick(); tick(); tick();      // R5 calendar stopped over midnight
        wr(A_CTRL, 32'd0); idle(); tick(); idle();

        wr(A_CLR, 32'h1F); tick();
        step(1, 1, A_CLR, 32'h02);                      // R8 event beats clear
        step(0, 1, A_CLR, 32'h02);                      // R8 plain clear
        wr(A_IEN, 32'h1F); tick();
        wr(A_IDIS, 32'hFFFF_FFFF);                      // R9 mask everything
        tick();
        wr(A_MODE, 32'd1); tick(); wr(A_MODE, 32'd0);  // R10

        for (int i = 0; i < 600; i++) begin            // mixed traffic
            int r;
            bit tk;
            r = int'($urandom % 16);
            tk = ($urandom % 3) == 0;
            case (r)
                0: step(tk, 1, A_CLR,  32'($urandom % 32));
                1: step(tk, 1, A_IEN,  32'($urandom % 32));
                2: step(tk, 1, A_IDIS, 32'($urandom % 32));
                3: step(tk, 1, A_TIME, 32'($urandom));  // R6 ignored while running
                default: step(tk, 0, 0, 32'd0);
            endcase
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule